// File: doc/BRIEF.md
# Cached DRAM refresh and start-up sequencer

This block sits on the controller side of a cached DRAM, which is a DRAM array with an on-chip row cache. It drives the memory's control pins through the power-up initialization. It then keeps the array refreshed for as long as the system runs. The start-up walk has two parts. First come a fixed number of row-enable-only dummy cycles. Then come two reads to different rows in each of the four banks, which prime the cache logic. Only after that walk does the block report itself ready and let the host at the memory.

Refresh follows the initialization. A parameterized clock-cycle interval sets a pending flag. The pending flag raises a request to the host arbiter. The block runs one refresh cycle when the arbiter grants the request while the host is not busy on the bus. A build-time parameter selects one of two refresh forms:

- **Counter-driven refresh.** The memory's refresh pin is held low across the falling edge of row enable, and select is released for the cycle.
- **Address-driven refresh.** This is a write-type cycle with refresh, write/read and output enable all inactive, and the column strobe is never clocked. A ten-bit row counter supplies the row address.

Top module: `edram_refresh_seq`

## Requirements
- R1: While reset is asserted, rowEnN, refreshN, colStrobeN, outEnN and selN are all high (inactive), and wrMode, rowAddr, refReq, initDone and hostOk are all zero.
- R2: The first INIT_DUMMY memory cycles after reset are row-enable-only cycles. In each of them wrMode=1, refreshN=1, outEnN=1 and selN=0. Dummy cycle i carries rowAddr=i.
- R3: Eight read cycles follow the dummy cycles. For reads in the order k=0..7, rowAddr has bank k/2 in bits [9:8] and k%2 in bits [7:0], with every other bit zero. Each read has wrMode=0, outEnN=0 and selN=0. colStrobeN goes low for one clock inside each read's active phase and stays high in every other cycle.
- R4: initDone rises at the clock edge that ends the precharge of the last initialization read, which is 16*(T_ACT+T_PRE+2) edges after reset release with the default counts. Once high, initDone stays high. While initDone is low, hostOk and refReq are both low.
- R5: refReq rises exactly REF_INTERVAL clocks after initDone rises. After that, the interval recurs every REF_INTERVAL clocks.
- R6: A refresh cycle starts only from idle, at an edge where refGrant=1 and hostBusy=0. refReq falls at that edge, and rowEnN falls one clock later. While refGrant is low or hostBusy is high, no refresh cycle starts and refReq stays high.
- R7: With ROW_REFRESH=0, each refresh cycle drives refreshN low one clock before rowEnN falls and keeps it low through the cycle. The same cycle has selN=1, wrMode=0, outEnN=1, colStrobeN=1 and rowAddr=0.
- R8: With ROW_REFRESH=1, each refresh cycle has refreshN=1, wrMode=1, outEnN=1, colStrobeN=1 and selN=0. rowAddr steps through 0,1,2,... across refresh cycles and wraps from 1023 back to 0, so bit 10 is always zero.
- R9: In every memory cycle, rowEnN stays low for exactly T_ACT clocks. Between two cycles it stays high for at least T_PRE+2 clocks.
- R10: hostOk is high only when initDone is high and no memory cycle is in progress (rowEnN and refreshN are both high). It is high in an idle clock after initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refGrant | input | 1 | Arbiter grants the pending refresh |
| hostBusy | input | 1 | Host is currently using the memory bus |
| rowEnN | output | 1 | Row enable to memory, active low |
| refreshN | output | 1 | Counter-refresh pin to memory, active low |
| wrMode | output | 1 | Write/read select, 1 = write-type cycle |
| outEnN | output | 1 | Output enable to memory, active low |
| colStrobeN | output | 1 | Column address strobe, active low |
| selN | output | 1 | Chip select, active low |
| rowAddr | output | ROW_W | Row address for the current cycle |
| refReq | output | 1 | Refresh pending, request to arbiter |
| initDone | output | 1 | Initialization sequence complete |
| hostOk | output | 1 | Host may use the memory now |

## Verification
The bench uses two instances: one with counter-driven refresh and one with address-driven refresh and a short interval. This covers the following failure modes:

- **Row counter wrap.** The address-driven instance runs past the row counter's wrap. A counter that skipped a row, let bit 10 change or failed to wrap would break the expected row sequence.
- **Dummy and read ordering.** A sequencer that reordered dummies and reads, or put both reads of a bank on one row, would fail the cycle-by-cycle pin comparison.
- **Arbiter handshake.** The bench holds the grant low, and then raises it while the host reports busy. A refresh that started without the full handshake, or a request that dropped early, would be caught.
- **Timing windows.** The exact init length, the exact interval to the first request, the refresh-pin setup edge and the active-phase width are all measured in clocks. An off-by-one in any of them is reported.

// File: rtl/edram_seq_pkg.sv
package edram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_PRE   = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    CY_DUMMY  = 2'd0,
    CY_INITRD = 2'd1,
    CY_REF    = 2'd2
  } cycKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadAct;
    logic loadPre;
    logic beginInit;
    logic beginRef;
    logic endInit;
    logic endRef;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic timerZero;
    logic inDummy;
    logic initDone;
    logic pending;
  } seqStatus_t;

  localparam int BANK_COUNT     = 4;
  localparam int READS_PER_BANK = 2;
  localparam int BANK_LSB       = 8;
  localparam int REF_ROW_BITS   = 10;

endpackage

// File: rtl/edram_seq_dp.sv
module edram_seq_dp
  import edram_seq_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int INIT_DUMMY   = 8,
  parameter int REF_INTERVAL = 15000,
  parameter int T_ACT        = 4,
  parameter int T_PRE        = 3,
  parameter int ROW_REFRESH  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  output seqStatus_t       stat,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int INIT_READS = BANK_COUNT * READS_PER_BANK;
  localparam int INIT_TOTAL = INIT_DUMMY + INIT_READS;
  localparam int INIT_W     = $clog2(INIT_TOTAL + 1);
  localparam int TMR_MAX    = (T_ACT > T_PRE) ? T_ACT : T_PRE;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int IVL_W      = $clog2(REF_INTERVAL + 1);

  logic [TMR_W-1:0]        timer;
  logic [INIT_W-1:0]       initCnt;
  logic [INIT_W-1:0]       rdIdx;
  logic [IVL_W-1:0]        ivlCnt;
  logic [REF_ROW_BITS-1:0] refRow;
  logic                    pending;
  logic                    initDone;
  logic                    ivlWrap;
  logic [ROW_W-1:0]        dummyAddr;
  logic [ROW_W-1:0]        rdAddr;
  logic [ROW_W-1:0]        refAddr;

  // phase timer shared by the active and precharge phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (stb.loadAct)   timer <= TMR_W'(T_ACT - 1);
    else if (stb.loadPre)   timer <= TMR_W'(T_PRE - 1);
    else if (timer != '0)   timer <= timer - 1'b1;
  end

  // start-up progress: dummies first, then bank-priming reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            initCnt <= '0;
    else if (stb.endInit) initCnt <= initCnt + 1'b1;
  end

  assign initDone  = (initCnt == INIT_W'(INIT_TOTAL));
  assign rdIdx     = initCnt - INIT_W'(INIT_DUMMY);
  assign dummyAddr = ROW_W'(initCnt);
  assign rdAddr    = (ROW_W'(rdIdx / INIT_W'(READS_PER_BANK)) << BANK_LSB)
                   | ROW_W'(rdIdx % INIT_W'(READS_PER_BANK));

  // refresh interval timer and sticky pending flag
  assign ivlWrap = (ivlCnt == IVL_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ivlCnt <= '0;
    else if (!initDone) ivlCnt <= '0;
    else if (ivlWrap)   ivlCnt <= '0;
    else                ivlCnt <= ivlCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pending <= 1'b0;
    else if (initDone && ivlWrap) pending <= 1'b1;
    else if (stb.beginRef)        pending <= 1'b0;
  end

  // external refresh row, ten bits, wraps on its own
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           refRow <= '0;
    else if (stb.endRef) refRow <= refRow + 1'b1;
  end

  assign refAddr = (ROW_REFRESH != 0) ? ROW_W'(refRow) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rowAddr <= '0;
    else if (stb.beginInit) rowAddr <= stat.inDummy ? dummyAddr : rdAddr;
    else if (stb.beginRef)  rowAddr <= refAddr;
  end

  assign stat.timerZero = (timer == '0);
  assign stat.inDummy   = (initCnt < INIT_W'(INIT_DUMMY));
  assign stat.initDone  = initDone;
  assign stat.pending   = pending;

endmodule

// File: rtl/edram_seq_ctrl.sv
module edram_seq_ctrl
  import edram_seq_pkg::*;
#(
  parameter int ROW_REFRESH = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t stat,
  input  logic       refGrant,
  input  logic       hostBusy,
  output seqStrobe_t stb,
  output logic       rowEnN,
  output logic       refreshN,
  output logic       wrMode,
  output logic       outEnN,
  output logic       colStrobeN,
  output logic       selN,
  output logic       hostOk
);

  localparam bit COUNTER_MODE = (ROW_REFRESH == 0);

  seqState_t state, nextState;
  cycKind_t  kind, nextKind;
  logic      busyCyc;
  logic      counterRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= CY_DUMMY;
    end else begin
      state <= nextState;
      kind  <= nextKind;
    end
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    nextKind  = kind;
    case (state)
      ST_IDLE: begin
        if (!stat.initDone) begin
          stb.beginInit = 1'b1;
          nextState     = ST_SETUP;
          nextKind      = stat.inDummy ? CY_DUMMY : CY_INITRD;
        end else if (stat.pending && refGrant && !hostBusy) begin
          stb.beginRef = 1'b1;
          nextState    = ST_SETUP;
          nextKind     = CY_REF;
        end
      end
      ST_SETUP: begin
        stb.loadAct = 1'b1;
        nextState   = ST_ACT;
      end
      ST_ACT: begin
        if (stat.timerZero) begin
          stb.loadPre = 1'b1;
          nextState   = ST_PRE;
        end
      end
      ST_PRE: begin
        if (stat.timerZero) begin
          if (kind == CY_REF) stb.endRef  = 1'b1;
          else                stb.endInit = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // pin decode from registered state and cycle kind
  assign busyCyc    = (state != ST_IDLE);
  assign counterRef = busyCyc && (kind == CY_REF) && COUNTER_MODE;

  assign rowEnN     = (state != ST_ACT);
  assign refreshN   = !counterRef;
  assign wrMode     = busyCyc && ((kind == CY_DUMMY) ||
                                  ((kind == CY_REF) && !COUNTER_MODE));
  assign outEnN     = !(busyCyc && (kind == CY_INITRD));
  assign colStrobeN = !((state == ST_ACT) && (kind == CY_INITRD) && stat.timerZero);
  assign selN       = !(busyCyc && !counterRef);
  assign hostOk     = stat.initDone && (state == ST_IDLE);

endmodule

// File: rtl/edram_refresh_seq.sv
module edram_refresh_seq
  import edram_seq_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int INIT_DUMMY   = 8,
  parameter int REF_INTERVAL = 15000,
  parameter int T_ACT        = 4,
  parameter int T_PRE        = 3,
  parameter int ROW_REFRESH  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGrant,
  input  logic             hostBusy,
  output logic             rowEnN,
  output logic             refreshN,
  output logic             wrMode,
  output logic             outEnN,
  output logic             colStrobeN,
  output logic             selN,
  output logic [ROW_W-1:0] rowAddr,
  output logic             refReq,
  output logic             initDone,
  output logic             hostOk
);

  seqStrobe_t stb;
  seqStatus_t stat;

  edram_seq_ctrl #(
    .ROW_REFRESH(ROW_REFRESH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .refGrant  (refGrant),
    .hostBusy  (hostBusy),
    .stb       (stb),
    .rowEnN    (rowEnN),
    .refreshN  (refreshN),
    .wrMode    (wrMode),
    .outEnN    (outEnN),
    .colStrobeN(colStrobeN),
    .selN      (selN),
    .hostOk    (hostOk)
  );

  edram_seq_dp #(
    .ROW_W       (ROW_W),
    .INIT_DUMMY  (INIT_DUMMY),
    .REF_INTERVAL(REF_INTERVAL),
    .T_ACT       (T_ACT),
    .T_PRE       (T_PRE),
    .ROW_REFRESH (ROW_REFRESH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .stat   (stat),
    .rowAddr(rowAddr)
  );

  assign refReq   = stat.pending;
  assign initDone = stat.initDone;

endmodule

// File: rtl/edram_seq_checker.sv
module edram_seq_checker #(
  parameter int T_ACT       = 4,
  parameter int ROW_REFRESH = 0
) (
  input logic clk,
  input logic rstN,
  input logic refGrant,
  input logic hostBusy,
  input logic rowEnN,
  input logic refreshN,
  input logic wrMode,
  input logic outEnN,
  input logic colStrobeN,
  input logic selN,
  input logic refReq,
  input logic initDone,
  input logic hostOk
);

  logic [15:0] actLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        actLen <= '0;
    else if (!rowEnN) actLen <= actLen + 1'b1;
    else              actLen <= '0;
  end

  assert_active_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowEnN) |-> (actLen == 16'(T_ACT)));

  assert_cas_in_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    !colStrobeN |-> (!outEnN && !wrMode && !rowEnN));

  assert_gate_host_R4: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (!hostOk && !refReq));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_grant_handshake_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refReq) |-> ($past(refGrant) && !$past(hostBusy)));

  assert_refpin_setup_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rowEnN) |-> $stable(refreshN));

  assert_host_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostOk |-> (rowEnN && refreshN && colStrobeN && initDone));

  generate
    if (ROW_REFRESH != 0) begin : g_rowMode
      assert_row_refresh_pins_R8: assert property (@(posedge clk) disable iff (!rstN)
        (initDone && !rowEnN) |-> (refreshN && wrMode && outEnN && colStrobeN && !selN));
    end else begin : g_cntMode
      assert_cnt_refresh_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
        (initDone && !rowEnN) |-> (!refreshN && selN && !wrMode && outEnN && colStrobeN));
    end
  endgenerate

endmodule

bind edram_refresh_seq edram_seq_checker #(
  .T_ACT      (T_ACT),
  .ROW_REFRESH(ROW_REFRESH)
) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .refGrant  (refGrant),
  .hostBusy  (hostBusy),
  .rowEnN    (rowEnN),
  .refreshN  (refreshN),
  .wrMode    (wrMode),
  .outEnN    (outEnN),
  .colStrobeN(colStrobeN),
  .selN      (selN),
  .refReq    (refReq),
  .initDone  (initDone),
  .hostOk    (hostOk)
);

// File: tb/edram_refresh_seq_bench.sv
module edram_refresh_seq_bench;

  localparam int T_ACT   = 4;
  localparam int T_PRE   = 3;
  localparam int IVL_A   = 40;
  localparam int IVL_B   = 16;
  localparam int ROWS_B  = 1030;
  localparam int INIT_N  = 16;

  typedef struct packed {
    logic        refN;
    logic        wr;
    logic        oeN;
    logic        sN;
    logic [10:0] row;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic grantA = 1'b0, busyA = 1'b0, grantB = 1'b1, busyB = 1'b0;
  logic rowEnNA, refreshNA, wrModeA, outEnNA, colStrobeNA, selNA, refReqA, initDoneA, hostOkA;
  logic rowEnNB, refreshNB, wrModeB, outEnNB, colStrobeNB, selNB, refReqB, initDoneB, hostOkB;
  logic [10:0] rowAddrA, rowAddrB;

  edram_refresh_seq #(.REF_INTERVAL(IVL_A), .T_ACT(T_ACT), .T_PRE(T_PRE), .ROW_REFRESH(0))
  u_edram_refresh_seq (
    .clk(clk), .rstN(rstN), .refGrant(grantA), .hostBusy(busyA),
    .rowEnN(rowEnNA), .refreshN(refreshNA), .wrMode(wrModeA), .outEnN(outEnNA),
    .colStrobeN(colStrobeNA), .selN(selNA), .rowAddr(rowAddrA),
    .refReq(refReqA), .initDone(initDoneA), .hostOk(hostOkA));

  edram_refresh_seq #(.REF_INTERVAL(IVL_B), .T_ACT(T_ACT), .T_PRE(T_PRE), .ROW_REFRESH(1))
  u_edram_refresh_seq_row (
    .clk(clk), .rstN(rstN), .refGrant(grantB), .hostBusy(busyB),
    .rowEnN(rowEnNB), .refreshN(refreshNB), .wrMode(wrModeB), .outEnN(outEnNB),
    .colStrobeN(colStrobeNB), .selN(selNB), .rowAddr(rowAddrB),
    .refReq(refReqB), .initDone(initDoneB), .hostOk(hostOkB));

  int nChecks = 0;
  int nFail = 0;
  item_t qA[$];
  item_t qB[$];
  int popped[2] = '{0, 0};
  logic prevEn[2] = '{1'b1, 1'b1};
  logic prevRf[2] = '{1'b1, 1'b1};
  logic seenCyc[2] = '{1'b0, 1'b0};
  logic sawCas[2] = '{1'b0, 1'b0};
  logic isRead[2] = '{1'b0, 1'b0};
  int actLen[2] = '{0, 0};
  int gap[2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // driver: expected memory cycles pushed into the scoreboard
  task automatic pushItem(input int u, input item_t it);
    if (u == 0) qA.push_back(it);
    else        qB.push_back(it);
  endtask

  task automatic loadExpected();
    for (int u = 0; u < 2; u++) begin
      for (int i = 0; i < 8; i++) pushItem(u, {1'b1, 1'b1, 1'b1, 1'b0, 11'(i)});
      for (int k = 0; k < 8; k++)
        pushItem(u, {1'b1, 1'b0, 1'b0, 1'b0, 11'(((k / 2) << 8) | (k % 2))});
    end
    for (int i = 0; i < 600; i++) pushItem(0, {1'b0, 1'b0, 1'b1, 1'b1, 11'd0});
    for (int i = 0; i < ROWS_B + 80; i++) pushItem(1, {1'b1, 1'b1, 1'b1, 1'b0, 11'(i % 1024)});
  endtask

  // monitor: pops and compares one item per row-enable fall
  task automatic observe(input int u, input logic rEn, input logic rfN, input logic wr,
                         input logic oeN, input logic cN, input logic sN, input logic hok,
                         input logic done, input logic req, input logic [10:0] row);
    item_t cur;
    item_t expItem;
    string tag;
    if (prevEn[u] && !rEn) begin
      cur = {rfN, wr, oeN, sN, row};
      tag = (popped[u] < 8) ? "R2" : (popped[u] < 16) ? "R3" : (u == 0) ? "R7" : "R8";
      if ((u == 0 && qA.size() == 0) || (u == 1 && qB.size() == 0)) begin
        chk(1'b0, tag, "unexpected memory cycle", longint'(cur), 0);
      end else begin
        expItem = (u == 0) ? qA.pop_front() : qB.pop_front();
        popped[u]++;
        chk(cur == expItem, tag, "cycle pins", longint'(cur), longint'(expItem));
      end
      if (!rfN) chk(prevRf[u] == 1'b0, "R7", "refresh pin setup", longint'(prevRf[u]), 0);
      if (seenCyc[u]) chk(gap[u] >= T_PRE + 2, "R9", "high gap", gap[u], T_PRE + 2);
      seenCyc[u] = 1'b1;
      actLen[u]  = 1;
      sawCas[u]  = 1'b0;
      isRead[u]  = !oeN;
    end else if (!rEn) begin
      actLen[u]++;
    end else if (!prevEn[u] && rEn) begin
      chk(actLen[u] == T_ACT, "R9", "active width", actLen[u], T_ACT);
      chk(sawCas[u] == isRead[u], "R3", "column strobe use", longint'(sawCas[u]), longint'(isRead[u]));
      gap[u] = 1;
    end else begin
      gap[u]++;
    end
    if (!cN) begin
      sawCas[u] = 1'b1;
      chk(!rEn && isRead[u], "R3", "column strobe outside read", longint'(rEn), 0);
    end
    if (hok) chk(rEn && rfN && done, "R10", "host ok during cycle", {rEn, rfN, done}, 3'b111);
    if (!done) chk(!hok && !req, "R4", "host/request before done", {hok, req}, 0);
    prevEn[u] = rEn;
    prevRf[u] = rfN;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      observe(0, rowEnNA, refreshNA, wrModeA, outEnNA, colStrobeNA, selNA, hostOkA, initDoneA, refReqA, rowAddrA);
      observe(1, rowEnNB, refreshNB, wrModeB, outEnNB, colStrobeNB, selNB, hostOkB, initDoneB, refReqB, rowAddrB);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (80000) @(negedge clk);
    chk(1'b0, "R5", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int c;
    loadExpected();
    repeat (3) @(negedge clk);
    chk(rowEnNA && refreshNA && colStrobeNA && outEnNA && selNA && !wrModeA &&
        !initDoneA && !refReqA && !hostOkA && rowAddrA == 0, "R1", "reset state A", 0, 1);
    chk(rowEnNB && refreshNB && colStrobeNB && outEnNB && selNB && !wrModeB &&
        !initDoneB && !refReqB && !hostOkB && rowAddrB == 0, "R1", "reset state B", 0, 1);
    rstN = 1'b1;

    c = 0;
    while (!initDoneA) begin @(negedge clk); c++; end
    chk(c == INIT_N * (T_ACT + T_PRE + 2), "R4", "init length", c, INIT_N * (T_ACT + T_PRE + 2));
    chk(popped[0] == INIT_N, "R4", "init cycle count", popped[0], INIT_N);
    chk(initDoneB == 1'b1, "R4", "second instance done", initDoneB, 1);

    c = 0;
    while (!refReqA) begin @(negedge clk); c++; end
    chk(c == IVL_A, "R5", "first interval", c, IVL_A);
    chk(hostOkA == 1'b1, "R10", "host ok when idle", hostOkA, 1);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(rowEnNA && refReqA, "R6", "no start without grant", {rowEnNA, refReqA}, 2'b11);
    end
    grantA = 1'b1;
    busyA  = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(rowEnNA && refReqA, "R6", "no start while host busy", {rowEnNA, refReqA}, 2'b11);
    end
    busyA = 1'b0;
    @(negedge clk);
    chk(!refReqA && rowEnNA, "R6", "request drops at start", {refReqA, rowEnNA}, 2'b01);
    chk(!refreshNA && selNA, "R7", "setup clock pins", {refreshNA, selNA}, 2'b01);
    @(negedge clk);
    chk(!rowEnNA, "R6", "row enable one clock later", rowEnNA, 0);

    while (popped[1] < INIT_N + ROWS_B) @(negedge clk);
    chk(popped[1] == INIT_N + ROWS_B, "R8", "row refresh count past wrap", popped[1], INIT_N + ROWS_B);
    chk(popped[0] >= INIT_N + 350, "R5", "sustained refresh rate", popped[0], INIT_N + 350);
    finishRun();
  end

endmodule